// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Control

This block is the control path of a single-ported synchronous burst SRAM. Its data bus is shared between reads and writes, and the block contains a small byte-lane storage array of its own. Every control input is sampled on the rising clock. Three chip selects and two address strobes open an access. One strobe belongs to a host processor and the other to a memory controller, and the two follow different priority and write-timing rules. A step input then walks a two-bit wrap-around burst counter in either linear or XOR (interleaved) order. Writes are qualified per byte lane, and a global write overrides the lane selects.

The bus drive enable is decided combinationally from output enable, the read-valid state and the write inputs of the current cycle. Any write indication turns the drivers off at once. An asynchronous sleep request is brought into the clock domain over two flops. While the block sleeps, no access runs, and a burst still in progress is dropped. After sleep ends, a programmable recovery window rejects new accesses and reports each rejected attempt on a one-cycle flag.

Top module: `sbsram_ctrl`

## Requirements
- R1: After reset, `dq_oe`, `reject` and `asleep` are low and `rdata` is zero.
- R2: An access opens only if `cs_main_n` is low, `cs_pos` is high and `cs_neg_n` is low at the clock edge. A controller-strobe write with any one of these inactive leaves the array unchanged.
- R3: While `cs_main_n` is high, a low host strobe neither opens an access nor ends the running burst, and the burst keeps stepping.
- R4: An access opened by the host strobe is a read at the start edge, and the write inputs at that edge are ignored. If the write inputs indicate a write at the next edge, that edge writes the same address.
- R5: An access opened by the controller strobe samples the write inputs at the start edge and writes at once if they indicate a write. The controller strobe is ignored whenever the host strobe is low.
- R6: A low `wr_all_n` writes all four lanes. Otherwise lane i (bits 8i+7..8i) is written only when `lane_wr_n` and `lane_sel_n[i]` are both low. A write is indicated when either of these conditions enables at least one lane.
- R7: `dq_oe` is high exactly when read data is valid, `oe_n` is low, no write is indicated on the current inputs and the block is awake. It follows `oe_n` and the write inputs without waiting for a clock. `rdata` is zero whenever `dq_oe` is low.
- R8: The burst keeps address bits above bit 1 fixed. The low two bits of beat k are (start+k) mod 4 when `order_xor` is 0 and start XOR k when it is 1, with the order latched at the start. A low `step_n` advances one beat, and a high `step_n` holds the beat.
- R9: In a continuing burst, each beat that indicates a write writes the current beat address with the lane qualification of that cycle.
- R10: A low controller strobe, or a low host strobe with `cs_main_n` low, while the chip selects are not all active ends the burst. `dq_oe` is low afterwards, and later step or write inputs have no effect until a new access opens.
- R11: `asleep` rises two edges after `sleep_req` rises and falls two edges after it falls. While asleep, no access runs and no lane is written. Stored data is intact after wake-up, and a burst in progress is dropped.
- R12: For `REC_CYC` edges after `asleep` falls, and while asleep, an attempted access is rejected and `reject` is high for the following cycle. The next attempt after that window is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_main_n | input | 1 | Primary chip select, active low; also gates the host strobe |
| cs_pos | input | 1 | Chip select, active high |
| cs_neg_n | input | 1 | Chip select, active low |
| host_stb_n | input | 1 | Host address strobe, active low, higher priority |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low, all lanes |
| lane_wr_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | NB | Per-lane write selects, active low |
| order_xor | input | 1 | Burst order: 1 interleaved (XOR), 0 linear |
| addr | input | AW | Word address |
| wdata | input | NB*BW | Write data |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| rdata | output | NB*BW | Read data, zero when not driven |
| dq_oe | output | 1 | Data bus drive enable |
| reject | output | 1 | Pulses after an access attempt refused by sleep or recovery |
| asleep | output | 1 | Synchronized sleep state |

## Verification
The bench builds the block with `AW=4` and `REC_CYC=3`. With these values the whole array is 16 words, so every word can be written and read back. The same setting lets all four start offsets be swept in both burst orders within one aligned quad, including wrap-around, and lets all 32 combinations of lane enable and lane selects be swept, plus global-write cases. The three-edge recovery window is short enough for the bench to probe its exact first accepted edge after wake-up.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Low two address bits of burst beat k from a start offset.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       xor_order);
    return xor_order ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/sbs_sleep_seq.sv
module sbs_sleep_seq #(
  parameter int REC_CYC = 4,
  localparam int RW = $clog2(REC_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic asleep,
  output logic blocked
);

  logic          sync1_q, sync2_q;
  logic [RW-1:0] rec_q, rec_d;

  always_comb begin
    if (sync2_q)              rec_d = RW'(REC_CYC);
    else if (rec_q != '0)     rec_d = rec_q - RW'(1);
    else                      rec_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      rec_q   <= '0;
    end else begin
      sync1_q <= sleep_req;
      sync2_q <= sync1_q;
      rec_q   <= rec_d;
    end
  end

  assign asleep  = sync2_q;
  assign blocked = sync2_q | (rec_q != '0);

  p_enter_two_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(sleep_req, 2));
  p_exit_two_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> !$past(sleep_req, 2));
  p_rec_countdown_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_q != '0 && !asleep) |=> (rec_q == $past(rec_q) - RW'(1)));

endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr import sbs_pkg::*; #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_xor,
  input  logic          step,
  output logic [AW-1:0] eff_addr
);

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q, cnt_d;
  logic          xor_q;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | step;
    cnt_d  = load ? 2'd0 : (cnt_q + {1'b0, step});
    if (load) eff_addr = ld_addr;
    else      eff_addr = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_d, xor_q)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      xor_q  <= 1'b0;
      cnt_q  <= 2'd0;
    end else begin
      if (load) begin
        base_q <= ld_addr;
        xor_q  <= ld_xor;
      end
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  p_step_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> (cnt_q == $past(cnt_q) + 2'd1));
  p_load_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == 2'd0));

endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [NB-1:0]    we,
  input  logic             re,
  input  logic [NB*BW-1:0] wdata,
  output logic [NB*BW-1:0] rdata_q
);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] store [DEPTH];
    logic [BW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[b]) store[addr] <= wdata[b*BW +: BW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rd_q <= '0;
      else if (re) rd_q <= store[addr];
    end

    assign rdata_q[b*BW +: BW] = rd_q;
  end

  p_no_rw_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    re |-> (we == '0));

endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl import sbs_pkg::*; #(
  parameter int AW      = 6,
  parameter int NB      = 4,
  parameter int BW      = 8,
  parameter int REC_CYC = 4,
  localparam int DW     = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_main_n,
  input  logic          cs_pos,
  input  logic          cs_neg_n,
  input  logic          host_stb_n,
  input  logic          ctl_stb_n,
  input  logic          step_n,
  input  logic          wr_all_n,
  input  logic          lane_wr_n,
  input  logic [NB-1:0] lane_sel_n,
  input  logic          order_xor,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          oe_n,
  input  logic          sleep_req,
  output logic [DW-1:0] rdata,
  output logic          dq_oe,
  output logic          reject,
  output logic          asleep
);

  // reset: asynchronous assert, synchronous release
  logic rs1_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_s <= rs1_q;
    end
  end

  logic          blocked;
  logic [AW-1:0] eff_addr;
  logic [DW-1:0] mem_q;

  logic sel_ok, host_req, host_start, ctl_start, try_start, go, start, cont, desel;
  logic wr_ind, do_write, do_read;
  logic [NB-1:0] be_raw, wr_be;
  logic active_q, active_d, rd_valid_q, rd_valid_d, reject_q, reject_d;

  sbs_sleep_seq #(.REC_CYC(REC_CYC)) u_sleep (
    .clk(clk), .rst_n(rst_s), .sleep_req(sleep_req),
    .asleep(asleep), .blocked(blocked)
  );

  always_comb begin
    sel_ok     = !cs_main_n && cs_pos && !cs_neg_n;
    host_req   = !host_stb_n && !cs_main_n;
    host_start = host_req && sel_ok;
    ctl_start  = !ctl_stb_n && host_stb_n && sel_ok;
    try_start  = host_start || ctl_start;
    desel      = !sel_ok && (!ctl_stb_n || host_req);
    go         = !blocked;
    start      = try_start && go;
    cont       = active_q && !try_start && !desel && go;

    if (!wr_all_n)       be_raw = '1;
    else if (!lane_wr_n) be_raw = ~lane_sel_n;
    else                 be_raw = '0;
    wr_ind = |be_raw;

    do_write = (start && ctl_start && wr_ind) || (cont && wr_ind);
    do_read  = (start && (host_start || !wr_ind)) || (cont && !wr_ind);
    wr_be    = do_write ? be_raw : '0;

    if (asleep)      active_d = 1'b0;
    else if (start)  active_d = 1'b1;
    else if (desel)  active_d = 1'b0;
    else             active_d = active_q;

    if (do_read)                         rd_valid_d = 1'b1;
    else if (do_write || desel || asleep) rd_valid_d = 1'b0;
    else                                 rd_valid_d = rd_valid_q;

    reject_d = try_start && blocked;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      active_q   <= 1'b0;
      rd_valid_q <= 1'b0;
      reject_q   <= 1'b0;
    end else begin
      active_q   <= active_d;
      rd_valid_q <= rd_valid_d;
      reject_q   <= reject_d;
    end
  end

  sbs_burst_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_s), .load(start), .ld_addr(addr),
    .ld_xor(order_xor), .step(cont && !step_n), .eff_addr(eff_addr)
  );

  sbs_lane_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
    .clk(clk), .rst_n(rst_s), .addr(eff_addr), .we(wr_be),
    .re(do_read), .wdata(wdata), .rdata_q(mem_q)
  );

  assign dq_oe  = rd_valid_q && !oe_n && !wr_ind && !asleep;
  assign rdata  = dq_oe ? mem_q : '0;
  assign reject = reject_q;

  p_quiet_blocked_r11: assert property (@(posedge clk) disable iff (!rst_s)
    blocked |-> (wr_be == '0 && !do_read));
  p_host_first_read_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (host_start && !blocked) |-> (wr_be == '0));
  p_global_all_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (!wr_all_n && wr_be != '0) |-> (wr_be == '1));
  p_desel_quiet_r10: assert property (@(posedge clk) disable iff (!rst_s)
    desel |=> !dq_oe);
  p_reject_cause_r12: assert property (@(posedge clk) disable iff (!rst_s)
    reject |-> $past(blocked));

endmodule

// File: tb/tb_sbsram_ctrl.sv
module tb_sbsram_ctrl;
  localparam int AW = 4;
  localparam int REC = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_main_n, cs_pos, cs_neg_n, host_stb_n, ctl_stb_n, step_n;
  logic wr_all_n, lane_wr_n, order_xor, oe_n, sleep_req;
  logic [3:0] lane_sel_n;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata;
  logic dq_oe, reject, asleep;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] model [16];

  always #5 clk = ~clk;

  sbsram_ctrl #(.AW(AW), .REC_CYC(REC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_main_n(cs_main_n), .cs_pos(cs_pos),
    .cs_neg_n(cs_neg_n), .host_stb_n(host_stb_n), .ctl_stb_n(ctl_stb_n),
    .step_n(step_n), .wr_all_n(wr_all_n), .lane_wr_n(lane_wr_n),
    .lane_sel_n(lane_sel_n), .order_xor(order_xor), .addr(addr),
    .wdata(wdata), .oe_n(oe_n), .sleep_req(sleep_req), .rdata(rdata),
    .dq_oe(dq_oe), .reject(reject), .asleep(asleep)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cs_main_n = 1'b0; cs_pos = 1'b1; cs_neg_n = 1'b0;
    host_stb_n = 1'b1; ctl_stb_n = 1'b1; step_n = 1'b1;
    wr_all_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = 4'hF; oe_n = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cstart(input logic [3:0] a, input logic [31:0] d,
                        input logic g, input logic be, input logic [3:0] bs);
    idle();
    ctl_stb_n = 1'b0; addr = a; wdata = d;
    wr_all_n = g; lane_wr_n = be; lane_sel_n = bs;
    tick();
    idle();
  endtask

  task automatic cwrite(input logic [3:0] a, input logic [31:0] d);
    cstart(a, d, 1'b0, 1'b1, 4'hF);
    model[a] = d;
  endtask

  task automatic cread(input logic [3:0] a, output logic [31:0] v);
    idle();
    ctl_stb_n = 1'b0; addr = a;
    tick();
    v = rdata;
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, d, e;
    idle();
    order_xor = 1'b0; sleep_req = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    // R1 reset state
    chk(dq_oe == 1'b0 && reject == 1'b0 && asleep == 1'b0 && rdata == 32'h0,
        "R1 reset outputs", {dq_oe, reject, asleep, rdata[28:0]}, 32'h0);

    // R5 controller-strobe writes land at once; fill whole array
    for (int i = 0; i < 16; i++) cwrite(4'(i), 32'hA5000000 ^ (32'(i) * 32'h01030507));
    for (int i = 0; i < 16; i++) begin
      cread(4'(i), v);
      chk(v == model[i], "R5 write/readback", v, model[i]);
    end

    // R2 any single select inactive blocks the write
    for (int s = 0; s < 3; s++) begin
      idle();
      ctl_stb_n = 1'b0; addr = 4'd5; wdata = 32'hDEAD0000 + 32'(s); wr_all_n = 1'b0;
      if (s == 0) cs_main_n = 1'b1;
      if (s == 1) cs_pos = 1'b0;
      if (s == 2) cs_neg_n = 1'b1;
      tick();
      idle();
      cread(4'd5, v);
      chk(v == model[5], "R2 select gating", v, model[5]);
    end

    // R4 host start: first-cycle write ignored, write on next edge
    idle();
    host_stb_n = 1'b0; addr = 4'd7; wr_all_n = 1'b0; wdata = 32'h11112222;
    tick();
    chk(dq_oe == 1'b0, "R7 write indicated forces tri-state", 32'(dq_oe), 32'h0);
    wr_all_n = 1'b1; #1;
    chk(rdata == model[7], "R4 first cycle is read", rdata, model[7]);
    host_stb_n = 1'b1; wr_all_n = 1'b0; wdata = 32'h33334444;
    tick();
    idle();
    model[7] = 32'h33334444;
    cread(4'd7, v);
    chk(v == model[7], "R4 second-edge write", v, model[7]);

    // R5 controller strobe ignored when host strobe low
    idle();
    host_stb_n = 1'b0; ctl_stb_n = 1'b0; addr = 4'd9; wr_all_n = 1'b0; wdata = 32'hBAD0BAD0;
    tick();
    idle();
    tick();
    cread(4'd9, v);
    chk(v == model[9], "R5 host priority", v, model[9]);

    // R6 lane qualification sweep
    for (int c = 0; c < 36; c++) begin
      logic [3:0] a;
      logic g, be;
      logic [3:0] bs;
      a = 4'(c);
      d = ~model[a] ^ 32'(c);
      g = (c >= 32) ? 1'b0 : 1'b1;
      be = (c >= 32) ? 1'(c & 1) : 1'((c >> 4) & 1);
      bs = 4'(c);
      e = model[a];
      for (int b = 0; b < 4; b++)
        if (!g || (!be && !bs[b])) e[b*8 +: 8] = d[b*8 +: 8];
      cstart(a, d, g, be, bs);
      model[a] = e;
      cread(a, v);
      chk(v == e, "R6 lane enables", v, e);
    end

    // R7 asynchronous output enable and write indication
    cread(4'd3, v);
    oe_n = 1'b1; #1;
    chk(dq_oe == 1'b0 && rdata == 32'h0, "R7 oe off", rdata, 32'h0);
    oe_n = 1'b0; #1;
    chk(dq_oe == 1'b1 && rdata == model[3], "R7 oe on", rdata, model[3]);
    lane_wr_n = 1'b0; lane_sel_n = 4'b1110; #1;
    chk(dq_oe == 1'b0, "R7 lane write tri-state", 32'(dq_oe), 32'h0);
    idle(); #1;

    // R8 burst order sweep over all offsets, both orders, with hold
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        order_xor = 1'(m);
        cread(4'(8 + s), v);
        chk(v == model[8 + s], "R8 beat 0", v, model[8 + s]);
        for (int k = 1; k < 4; k++) begin
          int lo;
          lo = m ? (s ^ k) : ((s + k) % 4);
          step_n = 1'b0;
          tick();
          chk(rdata == model[8 + lo], "R8 burst beat", rdata, model[8 + lo]);
          if (k == 3) begin
            step_n = 1'b1;
            tick();
            chk(rdata == model[8 + lo], "R8 hold beat", rdata, model[8 + lo]);
          end
        end
        idle();
      end
    end
    order_xor = 1'b0;

    // R3 host strobe with primary select high does not disturb burst
    cread(4'd8, v);
    host_stb_n = 1'b0; cs_main_n = 1'b1; step_n = 1'b0;
    tick();
    chk(rdata == model[9], "R3 burst continues", rdata, model[9]);
    idle();

    // R9 write burst, linear from offset 2 in quad 4..7
    cstart(4'd6, 32'hC0DE0000, 1'b0, 1'b1, 4'hF);
    model[6] = 32'hC0DE0000;
    for (int k = 1; k < 4; k++) begin
      step_n = 1'b0; wr_all_n = 1'b0; wdata = 32'hC0DE0000 + 32'(k);
      tick();
      model[4 + ((2 + k) % 4)] = 32'hC0DE0000 + 32'(k);
    end
    idle();
    for (int i = 4; i < 8; i++) begin
      cread(4'(i), v);
      chk(v == model[i], "R9 write burst", v, model[i]);
    end

    // R10 deselect ends burst
    cread(4'd12, v);
    ctl_stb_n = 1'b0; cs_pos = 1'b0;
    tick();
    chk(dq_oe == 1'b0, "R10 deselect tri-state", 32'(dq_oe), 32'h0);
    idle();
    step_n = 1'b0; wr_all_n = 1'b0; wdata = 32'hFEEDFEED;
    tick();
    chk(dq_oe == 1'b0, "R10 no continuation", 32'(dq_oe), 32'h0);
    idle();
    cread(4'd12, v);
    chk(v == model[12], "R10 no write at 12", v, model[12]);
    cread(4'd13, v);
    chk(v == model[13], "R10 no write at 13", v, model[13]);

    // R11 sleep entry, blocking, exit
    cread(4'd3, v);
    sleep_req = 1'b1;
    tick();
    chk(asleep == 1'b0, "R11 one edge not yet asleep", 32'(asleep), 32'h0);
    tick();
    chk(asleep == 1'b1 && dq_oe == 1'b0, "R11 asleep after two edges", {asleep, dq_oe}, 32'h2);
    cstart(4'd2, 32'h0BAD0BAD, 1'b0, 1'b1, 4'hF);
    chk(reject == 1'b1, "R12 reject while asleep", 32'(reject), 32'h1);
    tick();
    sleep_req = 1'b0;
    tick();
    chk(asleep == 1'b1, "R11 one edge still asleep", 32'(asleep), 32'h1);
    tick();
    chk(asleep == 1'b0, "R11 awake after two edges", 32'(asleep), 32'h0);
    for (int k = 0; k < REC; k++) begin
      cstart(4'd2, 32'h0BAD0000 + 32'(k), 1'b0, 1'b1, 4'hF);
      chk(reject == 1'b1, "R12 recovery reject", 32'(reject), 32'h1);
    end
    cstart(4'd3, 32'h5EED5EED, 1'b0, 1'b1, 4'hF);
    chk(reject == 1'b0, "R12 first accepted start", 32'(reject), 32'h0);
    model[3] = 32'h5EED5EED;
    cread(4'd2, v);
    chk(v == model[2], "R11 data kept, blocked writes dropped", v, model[2]);
    cread(4'd3, v);
    chk(v == model[3], "R12 post-recovery write", v, model[3]);
    cread(4'd0, v);
    chk(v == model[0], "R11 retention", v, model[0]);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule